// File: doc/BRIEF.md
# Data-Link Byte Serializer with Zero Stuffing

This block feeds the data-link bit slot of a T1 frame from a byte that the host writes. The framing logic raises a strobe in each cycle that owns a data-link slot. The block sends one bit on each strobe, least significant bit first. When the eighth payload bit of a byte has gone out, the block sets a buffer-empty flag and can pull an active-low interrupt. The host then has about 2 ms at the data-link rate to write the next byte. If no new byte arrives in time, the byte already held is sent again.

An optional zero stuffer inserts a 0 after every run of five transmitted 1s. This keeps the payload from matching the flag octet 01111110 or the all-ones abort. A stuffed 0 takes a slot of its own and pushes the rest of the byte back.

A second mode supports framing-pattern insertion. In this mode a new byte is taken from the holding register only when a byte starts in the same cycle as a multiframe-boundary pulse. Otherwise the byte in the shifter starts over. Software programs 0x1C for the Fs pattern in this mode.

Top module: `dl_serializer`

## Requirements
- R1: Each cycle with `slot_en` high sends exactly one bit. That bit appears on `tx_bit` with `tx_valid` high one clock later. Payload bits go out least significant bit first. `tx_valid` is low after any cycle without a slot.
- R2: The slot that carries the eighth payload bit of a byte sets `empty_flag` to 1, visible one clock later.
- R3: A `stat_rd` pulse clears `empty_flag`. If the read falls in the same cycle as the eighth payload bit, the flag stays set.
- R4: `irq_n` is low exactly while `empty_flag` is 1 and the interrupt enable (`cfg_wdata[2]`) is set.
- R5: If the host writes nothing between two bytes, the next byte repeats the held value unchanged.
- R6: A host write during a byte changes only the holding register, and the byte in progress finishes unaltered. A write in the same cycle as the slot that starts a byte is used for that byte.
- R7: When stuffing is enabled (`cfg_wdata[0]`) and the five previous bits were 1s, the next slot carries an inserted 0. That 0 does not advance the payload. The run count carries across byte boundaries and is cleared by any 0 sent, stuffed or payload. With stuffing on, no six 1s in a row ever appear.
- R8: With boundary mode set (`cfg_wdata[1]`), a byte loads from the holding register only if its first slot coincides with `mf_bound`. Otherwise the current byte is sent again. Stuffing is inactive in this mode.
- R9: After reset the holding register is 0x00, stuffing, boundary mode and interrupt enable are off, `empty_flag` is 0, `irq_n` is 1 and `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Data-link slot strobe from the framing logic |
| mf_bound | input | 1 | Multiframe boundary pulse |
| host_we | input | 1 | Host write strobe for the transmit byte |
| host_wdata | input | W | Transmit byte |
| cfg_we | input | 1 | Host write strobe for the control bits |
| cfg_wdata | input | 3 | [0] stuffing, [1] boundary mode, [2] interrupt enable |
| stat_rd | input | 1 | Status read; clears the buffer-empty flag |
| tx_bit | output | 1 | Serial data-link bit |
| tx_valid | output | 1 | High when `tx_bit` carries a slot's bit |
| empty_flag | output | 1 | Buffer-empty status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The flag can be set and cleared in the same cycle: a status read can land on the slot that carries the eighth payload bit. The bench drives `stat_rd` together with that slot and expects the flag to stay set, since the new byte-empty event wins. A host write can likewise land on the slot that opens a byte. The bench pairs both in one cycle and expects the scoreboarded stream to carry the freshly written byte, not the held one.

// File: rtl/dl_serializer.sv
module dl_serializer #(
  parameter int W   = 8,
  parameter int RUN = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot_en,
  input  logic         mf_bound,
  input  logic         host_we,
  input  logic [W-1:0] host_wdata,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_wdata,
  input  logic         stat_rd,
  output logic         tx_bit,
  output logic         tx_valid,
  output logic         empty_flag,
  output logic         irq_n
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam int OW = $clog2(RUN + 1);

  logic [W-1:0]  hold_q, cur_q;
  logic [IW-1:0] idx_q;
  logic [OW-1:0] ones_q;
  logic          stuff_q, mf_q, ien_q, flag_q, bit_q, vld_q;

  wire stuff_now = stuff_q && !mf_q && (ones_q == OW'(RUN));
  wire start     = (idx_q == '0) && !stuff_now;
  wire reload    = start && (!mf_q || mf_bound);
  wire [W-1:0] src    = host_we ? host_wdata : hold_q;
  wire [W-1:0] byte_v = reload ? src : cur_q;
  wire out_bit   = stuff_now ? 1'b0 : byte_v[idx_q];
  wire byte_done = slot_en && !stuff_now && (idx_q == IW'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      cur_q   <= '0;
      idx_q   <= '0;
      ones_q  <= '0;
      stuff_q <= 1'b0;
      mf_q    <= 1'b0;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
      bit_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (host_we) hold_q <= host_wdata;
      if (cfg_we) {ien_q, mf_q, stuff_q} <= cfg_wdata;
      vld_q <= slot_en;
      if (slot_en) begin
        bit_q <= out_bit;
        if (reload) cur_q <= src;
        if (!out_bit) ones_q <= '0;
        else if (ones_q != OW'(RUN)) ones_q <= ones_q + 1'b1;
        if (!stuff_now) idx_q <= (idx_q == IW'(W - 1)) ? '0 : idx_q + 1'b1;
      end
      if (byte_done) flag_q <= 1'b1;
      else if (stat_rd) flag_q <= 1'b0;
    end
  end

  assign tx_bit     = bit_q;
  assign tx_valid   = vld_q;
  assign empty_flag = flag_q;
  assign irq_n      = !(flag_q && ien_q);

  a_r1_no_slot_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> !tx_valid);
  a_r2_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> empty_flag);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !byte_done) |=> (!empty_flag && irq_n));
  a_r7_stuffed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && stuff_now) |=> (tx_valid && !tx_bit && idx_q == $past(idx_q)));
  a_r7_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OW'(RUN));
  a_r6_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_en) |=> $stable(cur_q));
endmodule

// File: tb/sim_dl_serializer.sv
module sim_dl_serializer;
  logic clk = 0, rst_n = 0;
  logic slot_en = 0, mf_bound = 0, host_we = 0, cfg_we = 0, stat_rd = 0;
  logic [7:0] host_wdata = 0;
  logic [2:0] cfg_wdata = 0;
  logic tx_bit, tx_valid, empty_flag, irq_n;

  dl_serializer u0 (.clk, .rst_n, .slot_en, .mf_bound, .host_we, .host_wdata,
    .cfg_we, .cfg_wdata, .stat_rd, .tx_bit, .tx_valid, .empty_flag, .irq_n);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [7:0] m_hold = 0, m_cur = 0;
  int m_idx = 0, m_ones = 0, run1 = 0;
  bit m_stuff = 0, m_mf = 0, m_ien = 0, m_flag = 0, finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && tx_valid) begin
    if (exp_q.size() == 0) check(0, "R1", tx_bit, -1);
    else begin
      automatic bit e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(tx_bit == e, t, tx_bit, e);
    end
    run1 = tx_bit ? run1 + 1 : 0;
    if (m_stuff && !m_mf) check(run1 <= 5, "R7", run1, 5);
  end

  task automatic cyc(bit s, bit mfb = 0, bit we = 0, logic [7:0] wd = 0,
                     bit rd = 0, string tg = "R1");
    bit done = 0;
    slot_en = s; mf_bound = mfb; host_we = we; host_wdata = wd; stat_rd = rd;
    if (s) begin
      bit b;
      if (m_stuff && !m_mf && m_ones == 5) begin
        b = 0; exp_q.push_back(b); tag_q.push_back("R7");
      end else begin
        if (m_idx == 0 && (!m_mf || mfb)) m_cur = we ? wd : m_hold;
        b = m_cur[m_idx];
        exp_q.push_back(b); tag_q.push_back(tg);
        if (m_idx == 7) begin m_idx = 0; done = 1; end else m_idx++;
      end
      m_ones = b ? ((m_ones < 5) ? m_ones + 1 : 5) : 0;
    end
    if (we) m_hold = wd;
    m_flag = done ? 1'b1 : (rd ? 1'b0 : m_flag);
    @(posedge clk); #1;
    slot_en = 0; mf_bound = 0; host_we = 0; stat_rd = 0;
    check(empty_flag == m_flag, done ? "R2" : "R3", empty_flag, m_flag);
    check(irq_n == !(m_flag && m_ien), "R4", irq_n, !(m_flag && m_ien));
  endtask

  task automatic cfg(bit st, bit mf, bit ie);
    cfg_we = 1; cfg_wdata = {ie, mf, st};
    @(posedge clk); #1; cfg_we = 0;
    m_stuff = st; m_mf = mf; m_ien = ie;
  endtask

  task automatic slots(int n, string tg = "R1");
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0, 0, tg);
      if (i % 3 == 1) cyc(0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    check(empty_flag == 0, "R9", empty_flag, 0);
    check(irq_n == 1, "R9", irq_n, 1);
    check(tx_valid == 0, "R9", tx_valid, 0);
    slots(8, "R9");
    cfg(0, 0, 1);
    cyc(0, 0, 1, 8'hA5);
    cyc(0, 0, 0, 0, 1);
    slots(8, "R1");
    check(irq_n == 0, "R4", irq_n, 0);
    cfg(0, 0, 0);
    check(irq_n == 1, "R4", irq_n, 1);
    slots(8, "R5");
    slots(3, "R6");
    cyc(0, 0, 1, 8'h3C);
    slots(5, "R6");
    slots(8, "R6");
    cyc(1, 0, 1, 8'h81, 0, "R6");
    slots(6, "R6");
    cyc(1, 0, 0, 0, 1, "R3");
    check(empty_flag == 1, "R3", empty_flag, 1);
    cyc(0, 0, 0, 0, 1);
    check(empty_flag == 0, "R3", empty_flag, 0);
    cfg(1, 0, 1);
    cyc(0, 0, 1, 8'hFF);
    slots(20, "R7");
    cyc(0, 0, 1, 8'hF7);
    slots(18, "R7");
    cfg(1, 1, 0);
    cyc(0, 0, 1, 8'h1C);
    while (m_idx != 0 || m_ones == 5) cyc(1, 0, 0, 0, 0, "R8");
    slots(8, "R8");
    cyc(1, 1, 0, 0, 0, "R8");
    slots(7, "R8");
    cyc(0, 0, 1, 8'hFF);
    slots(8, "R8");
    cyc(1, 1, 0, 0, 0, "R8");
    slots(15, "R8");
    repeat (3) cyc(0);
    check(exp_q.size() == 0, "R1", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule